// File: doc/BRIEF.md
# Four-by-Five Matrix Keypad Scanner

This block reads a keypad of twenty switches placed where four row lines cross five column lines. The columns are outputs and the rows are inputs, with external pull-ups holding every row high while no switch is closed. A switch pulls its row low only while its column is driven low. While nothing is pressed, the scanner drives every column low, so any press shows up as a low row. It then walks the columns one at a time to find the switch, confirms the reading over several sample ticks, and reports a five-bit key index with a one-cycle strobe. It also raises an interrupt request that stays set until software acknowledges it.

The row inputs pass through a two-flop synchronizer. All decisions are taken on a slow sample tick made by dividing the clock. Once a key is accepted, the block reports no further key until every row has read high for the same number of ticks that a press needed.

The key index is row × 5 + column position, so the first legend row (1 2 3 4 *) gives codes 0 to 4 and the last row (C D E F ->) gives codes 15 to 19. Column position 0 is the column on output bit 4, and position 4 is the column on output bit 0.

Top module: `kpad_scan`

## Requirements
- R1: While reset is asserted, all five column outputs are high, and `code_vld_o`, `held_o` and `irq_o` are low.
- R2: From the first cycle after reset, while no scan is in progress and while a key is held, all column outputs are driven low. A row reading low (active low) is what starts a scan.
- R3: During a scan, exactly one column output is low. The columns are visited in position order 0 to 4, which is output bit 4 down to output bit 0, with one position per sample tick. A full pass that finds no low row returns to the idle drive.
- R4: The accepted code is row × 5 + position. Examples: key "1" gives 0, "#" gives 9, "F" gives 18 and "->" gives 19. Every code is below 20.
- R5: A key is accepted only after the same row has read low on the same column for DEB_TICKS consecutive sample ticks. Any other reading restarts detection from the idle drive. A press shorter than this produces no code.
- R6: `code_vld_o` is high for exactly one clock cycle per accepted key, and `code_o` holds the code in that cycle.
- R7: If several rows are low on the scanned column, the lowest-numbered row is reported. Across columns, the first column found in scan order is reported.
- R8: After acceptance, `held_o` is high and no further code is issued until all rows read high for DEB_TICKS consecutive ticks. A shorter release, or a change to another held key, issues no code.
- R9: `irq_o` rises together with each code strobe and stays high until `irq_ack_i` is sampled high. A new acceptance in the same cycle as an acknowledge leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_n_i | input | N_ROWS | Row sense lines, low when a closed switch meets a low column |
| irq_ack_i | input | 1 | Clears the interrupt request |
| col_n_o | output | N_COLS | Column drive lines, active low |
| code_o | output | clog2(N_ROWS*N_COLS) | Key index of the accepted key |
| code_vld_o | output | 1 | One-cycle strobe marking a new code |
| held_o | output | 1 | High from acceptance until release is confirmed |
| irq_o | output | 1 | Interrupt request, held until acknowledged |

## Verification
The hardest situations to reach from the ports are the ones where the switch matrix answers the column drive. These are a second key appearing mid-scan, two rows low on one column, and a release shorter than the debounce window. The bench models the switch matrix combinationally from `col_n_o`, so each scenario follows from choosing which switches are closed and for how many ticks. The cases include a short bounce of one tick, a hand-over from one held key to another, and an acknowledge held high through an acceptance. A behavioural model, fed the same switch set, is compared with every output on every clock.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_SCAN = 2'd1,
    KS_CONF = 2'd2,
    KS_HELD = 2'd3
  } kscan_st_t;
endpackage

// File: rtl/kpad_tick.sv
module kpad_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + W'(1);
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/kpad_rowpick.sv
module kpad_rowpick #(
  parameter int N_ROWS = 4,
  parameter int ROW_W  = 2
) (
  input  logic [N_ROWS-1:0] rows_n_i,
  output logic              hit_o,
  output logic [ROW_W-1:0]  idx_o
);
  // Lowest-numbered low row wins (R7)
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int r = N_ROWS - 1; r >= 0; r--) begin
      if (!rows_n_i[r]) begin
        hit_o = 1'b1;
        idx_o = ROW_W'(r);
      end
    end
  end
endmodule

// File: rtl/kpad_irq.sv
module kpad_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (rst)        irq_q <= 1'b0;
    else if (set_i) irq_q <= 1'b1;
    else if (ack_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  a_r9_rise_needs_set: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(set_i)) else $error("R9 irq rose without acceptance");

  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !ack_i) |=> irq_q) else $error("R9 irq dropped without ack");
endmodule

// File: rtl/kpad_scan.sv
module kpad_scan #(
  parameter int N_ROWS    = 4,
  parameter int N_COLS    = 5,
  parameter int TICK_DIV  = 50000,
  parameter int DEB_TICKS = 10
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [N_ROWS-1:0]                  row_n_i,
  input  logic                               irq_ack_i,
  output logic [N_COLS-1:0]                  col_n_o,
  output logic [$clog2(N_ROWS*N_COLS)-1:0]   code_o,
  output logic                               code_vld_o,
  output logic                               held_o,
  output logic                               irq_o
);
  import kpad_pkg::*;

  localparam int ROW_W  = (N_ROWS > 1) ? $clog2(N_ROWS) : 1;
  localparam int POS_W  = (N_COLS > 1) ? $clog2(N_COLS) : 1;
  localparam int CODE_W = $clog2(N_ROWS * N_COLS);
  localparam int DEB_W  = $clog2(DEB_TICKS + 1);
  localparam int N_KEYS = N_ROWS * N_COLS;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(N_COLS - 1);
  localparam logic [DEB_W-1:0] DEB_LAST = DEB_W'(DEB_TICKS - 1);

  // Column position p drives output bit N_COLS-1-p low
  function automatic logic [N_COLS-1:0] col_mask(input logic [POS_W-1:0] p);
    logic [N_COLS-1:0] m;
    for (int i = 0; i < N_COLS; i++) m[i] = (i != (N_COLS - 1 - int'(p)));
    return m;
  endfunction

  logic [N_ROWS-1:0] row_s1, row_s2;
  always_ff @(posedge clk) begin
    if (rst) begin
      row_s1 <= '1;
      row_s2 <= '1;
    end else begin
      row_s1 <= row_n_i;
      row_s2 <= row_s1;
    end
  end

  logic tick;
  kpad_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst(rst), .tick_o(tick));

  logic             hit;
  logic [ROW_W-1:0] pick_idx;
  kpad_rowpick #(.N_ROWS(N_ROWS), .ROW_W(ROW_W)) u_pick (
    .rows_n_i(row_s2), .hit_o(hit), .idx_o(pick_idx));

  kscan_st_t         st_q;
  logic [POS_W-1:0]  pos_q;
  logic [ROW_W-1:0]  row_q;
  logic [DEB_W-1:0]  deb_q;
  logic [N_COLS-1:0] col_q;
  logic [CODE_W-1:0] code_q;
  logic              vld_q, held_q;
  logic              same_key, accept;

  assign same_key = hit && (pick_idx == row_q);
  assign accept   = (st_q == KS_CONF) && tick && same_key && (deb_q == DEB_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= KS_IDLE;
      pos_q  <= '0;
      row_q  <= '0;
      deb_q  <= '0;
      col_q  <= '1;
      code_q <= '0;
      vld_q  <= 1'b0;
      held_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (st_q)
        KS_IDLE: begin
          col_q <= '0;
          if (tick && hit) begin
            st_q  <= KS_SCAN;
            pos_q <= '0;
            col_q <= col_mask('0);
          end
        end
        KS_SCAN: if (tick) begin
          if (hit) begin
            st_q  <= KS_CONF;
            row_q <= pick_idx;
            deb_q <= DEB_W'(1);
          end else if (pos_q == LAST_POS) begin
            st_q  <= KS_IDLE;
            col_q <= '0;
          end else begin
            pos_q <= pos_q + POS_W'(1);
            col_q <= col_mask(pos_q + POS_W'(1));
          end
        end
        KS_CONF: if (tick) begin
          if (accept) begin
            vld_q  <= 1'b1;
            code_q <= CODE_W'(int'(row_q) * N_COLS + int'(pos_q));
            held_q <= 1'b1;
            deb_q  <= '0;
            col_q  <= '0;
            st_q   <= KS_HELD;
          end else if (same_key) begin
            deb_q <= deb_q + DEB_W'(1);
          end else begin
            st_q  <= KS_IDLE;
            col_q <= '0;
          end
        end
        KS_HELD: if (tick) begin
          if (hit) begin
            deb_q <= '0;
          end else if (deb_q == DEB_LAST) begin
            st_q   <= KS_IDLE;
            held_q <= 1'b0;
          end else begin
            deb_q <= deb_q + DEB_W'(1);
          end
        end
        default: st_q <= KS_IDLE;
      endcase
    end
  end

  kpad_irq u_irq (.clk(clk), .rst(rst), .set_i(accept), .ack_i(irq_ack_i), .irq_o(irq_o));

  assign col_n_o    = col_q;
  assign code_o     = code_q;
  assign code_vld_o = vld_q;
  assign held_o     = held_q;

  a_r3_col_pattern: assert property (@(posedge clk) disable iff (rst)
    ($countones(~col_n_o) <= 1) || (col_n_o == '0)) else $error("R3 bad column pattern");

  a_r2_held_cols_low: assert property (@(posedge clk) disable iff (rst)
    held_o |-> (col_n_o == '0)) else $error("R2 columns not low while held");

  a_r4_code_range: assert property (@(posedge clk) disable iff (rst)
    code_vld_o |-> (int'(code_o) < N_KEYS)) else $error("R4 code out of range");

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    code_vld_o |=> !code_vld_o) else $error("R6 strobe longer than one cycle");

  a_r8_no_code_while_held: assert property (@(posedge clk) disable iff (rst)
    code_vld_o |-> !$past(held_o)) else $error("R8 code issued while held");

  a_r9_irq_with_code: assert property (@(posedge clk) disable iff (rst)
    code_vld_o |-> irq_o) else $error("R9 irq missing with code");
endmodule

// File: tb/sim_kpad_scan.sv
`timescale 1ns/1ps
module sim_kpad_scan;
  localparam int NR = 4;
  localparam int NC = 5;
  localparam int TD = 4;
  localparam int DB = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_ack = 1'b0;
  logic [NR*NC-1:0] keys = '0;
  logic [NR-1:0] row_n;
  logic [NC-1:0] col_n;
  logic [4:0] code;
  logic code_vld, held, irq;

  always #2.5 clk = ~clk;

  function automatic logic [NR-1:0] rows_of(input logic [NR*NC-1:0] k, input logic [NC-1:0] c);
    logic [NR-1:0] res = '1;
    for (int r = 0; r < NR; r++)
      for (int p = 0; p < NC; p++)
        if (k[r*NC+p] && !c[NC-1-p]) res[r] = 1'b0;
    return res;
  endfunction

  function automatic logic [NC-1:0] one_low(input int p);
    logic [NC-1:0] m = '1;
    m[NC-1-p] = 1'b0;
    return m;
  endfunction

  assign row_n = rows_of(keys, col_n);

  kpad_scan #(.N_ROWS(NR), .N_COLS(NC), .TICK_DIV(TD), .DEB_TICKS(DB)) u0 (
    .clk(clk), .rst(rst), .row_n_i(row_n), .irq_ack_i(irq_ack),
    .col_n_o(col_n), .code_o(code), .code_vld_o(code_vld), .held_o(held), .irq_o(irq));

  int checks = 0;
  int fails = 0;
  int ncodes = 0;
  int last_code = -1;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  // Behavioural reference model
  int m_tc, m_mode, m_pos, m_row, m_cnt, m_code;
  logic [NR-1:0] m_r1, m_r2;
  logic [NC-1:0] m_col;
  bit m_vld, m_held, m_irq;

  always @(posedge clk) begin
    bit tk, any, take;
    int low;
    tk = (m_tc == TD - 1);
    any = 0; low = 0;
    for (int r = NR - 1; r >= 0; r--) if (!m_r2[r]) begin any = 1; low = r; end
    take = 0;
    if (rst) begin
      m_tc <= 0; m_mode <= 0; m_pos <= 0; m_row <= 0; m_cnt <= 0; m_code <= 0;
      m_r1 <= '1; m_r2 <= '1; m_col <= '1; m_vld <= 0; m_held <= 0; m_irq <= 0;
    end else begin
      m_tc <= tk ? 0 : m_tc + 1;
      m_r1 <= rows_of(keys, m_col);
      m_r2 <= m_r1;
      m_vld <= 0;
      if (m_mode == 0) begin
        m_col <= '0;
        if (tk && any) begin m_mode <= 1; m_pos <= 0; m_col <= one_low(0); end
      end else if (m_mode == 1) begin
        if (tk) begin
          if (any) begin m_mode <= 2; m_row <= low; m_cnt <= 1; end
          else if (m_pos == NC - 1) begin m_mode <= 0; m_col <= '0; end
          else begin m_pos <= m_pos + 1; m_col <= one_low(m_pos + 1); end
        end
      end else if (m_mode == 2) begin
        if (tk) begin
          if (any && low == m_row) begin
            if (m_cnt + 1 == DB) begin
              take = 1; m_vld <= 1; m_code <= m_row * NC + m_pos;
              m_held <= 1; m_cnt <= 0; m_col <= '0; m_mode <= 3;
            end else m_cnt <= m_cnt + 1;
          end else begin m_mode <= 0; m_col <= '0; end
        end
      end else begin
        if (tk) begin
          if (any) m_cnt <= 0;
          else if (m_cnt + 1 == DB) begin m_mode <= 0; m_held <= 0; end
          else m_cnt <= m_cnt + 1;
        end
      end
      if (take) m_irq <= 1;
      else if (irq_ack) m_irq <= 0;
    end
  end

  bit started = 0;
  always @(negedge clk) begin
    if (started && !rst) begin
      chk(col_n == m_col, "R3 column drive", int'(col_n), int'(m_col));
      chk(code_vld == m_vld, "R6 strobe", int'(code_vld), int'(m_vld));
      if (m_vld) chk(int'(code) == m_code, "R4 code", int'(code), m_code);
      chk(held == m_held, "R8 held", int'(held), int'(m_held));
      chk(irq == m_irq, "R9 irq", int'(irq), int'(m_irq));
      if (code_vld) begin ncodes++; last_code = int'(code); end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input logic [NR*NC-1:0] k, input int hold);
    keys = k;
    cyc(hold);
  endtask

  task automatic release_all;
    keys = '0;
    cyc(60);
  endtask

  task automatic expect_codes(input string req, input int n0, input int n, input int c);
    chk(ncodes - n0 == n, req, ncodes - n0, n);
    if (n > 0) chk(last_code == c, req, last_code, c);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n0;
    cyc(3);
    // R1 reset state
    chk(col_n == '1, "R1 cols high in reset", int'(col_n), 31);
    chk(!code_vld && !held && !irq, "R1 outputs low in reset", int'({code_vld, held, irq}), 0);
    started = 1;
    rst = 1'b0;
    cyc(2);
    // R2 idle drive
    chk(col_n == '0, "R2 idle columns low", int'(col_n), 0);
    cyc(40);
    chk(ncodes == 0 && col_n == '0, "R2 no press no scan", ncodes, 0);

    // R4 key "1" and R9 ack
    n0 = ncodes; press(20'h1 << 0, 100);
    expect_codes("R4 key 1", n0, 1, 0);
    chk(irq == 1'b1, "R9 irq held", int'(irq), 1);
    chk(held == 1'b1, "R8 held while pressed", int'(held), 1);
    irq_ack = 1'b1; cyc(1); irq_ack = 1'b0; cyc(1);
    chk(irq == 1'b0, "R9 ack clears", int'(irq), 0);
    release_all();
    chk(held == 1'b0, "R8 held clears after release", int'(held), 0);

    n0 = ncodes; press(20'h1 << 19, 100); release_all();
    expect_codes("R4 key arrow", n0, 1, 19);
    n0 = ncodes; press(20'h1 << 18, 100); release_all();
    expect_codes("R4 key F", n0, 1, 18);
    n0 = ncodes; press(20'h1 << 9, 100); release_all();
    expect_codes("R4 key hash", n0, 1, 9);

    // R5 short press
    n0 = ncodes; press(20'h1 << 12, 2 * TD); release_all();
    expect_codes("R5 short press ignored", n0, 0, 0);

    // R7 priority
    n0 = ncodes; press((20'h1 << 5) | (20'h1 << 10), 100); release_all();
    expect_codes("R7 lowest row wins", n0, 1, 5);
    n0 = ncodes; press((20'h1 << 9) | (20'h1 << 2), 100); release_all();
    expect_codes("R7 scan order wins", n0, 1, 2);

    // R8 hand-over between held keys
    n0 = ncodes; press(20'h1 << 3, 100); press((20'h1 << 3) | (20'h1 << 12), 40);
    press(20'h1 << 12, 60); release_all();
    expect_codes("R8 no code on hand-over", n0, 1, 3);

    // R8 short release
    n0 = ncodes; press(20'h1 << 7, 100); press('0, TD); press(20'h1 << 7, 60); release_all();
    expect_codes("R8 short release ignored", n0, 1, 7);

    // R9 set wins over ack
    irq_ack = 1'b1;
    n0 = ncodes; press(20'h1 << 14, 100);
    expect_codes("R9 code under ack", n0, 1, 14);
    chk(irq == 1'b0, "R9 ack after set clears", int'(irq), 0);
    irq_ack = 1'b0;
    release_all();

    // R3 scan reaches last column
    n0 = ncodes; press(20'h1 << 4, 100); release_all();
    expect_codes("R3 last column found", n0, 1, 4);

    finish_run();
  end
endmodule